// File: doc/BRIEF.md
# Edge-Latched Interrupt Enable and Status Register

This block holds one byte-wide register at a single bus address. A write sets a per-source enable mask, and a read returns a per-source latched status. There are six sources, and the two top bits of the byte read back as zero. The source signals are plain asynchronous inputs, such as counter outputs or port pins. Each one passes through a two-flop synchroniser, then an edge detector. A rising edge on an enabled source sets its status bit, and the bit stays set.

There is no separate clear register. To clear a status bit, software writes 0 to that source's enable bit. The board interrupt depends only on the whole status vector going from all-zero to non-zero. To re-arm, software first disables the sources that fired, then checks that the status reads zero, then enables them again.

The parameter `REQ_STYLE` selects the request style. In level style, the request stays high while any status bit is set. In pulse style, the block gives one single-cycle pulse each time the status goes from zero to non-zero.

Top module: `eirq_reg`

## Requirements
- R1: After the active-low asynchronous reset, every enable bit and every status bit is 0, and `irq_o` is low.
- R2: A write with `bus_sel_i`=1, `bus_we_i`=1 and `bus_addr_i`=0x1E loads `bus_wdata_i[5:0]` into the enable mask. Bit i enables source i, and bits 7:6 of the write data are ignored.
- R3: If source i is enabled, a rising edge on `src_i[i]` sets status bit i. The bit stays set after the source falls.
- R4: A rising edge on a source whose enable bit is 0 leaves its status bit at 0.
- R5: Writing 0 to enable bit i clears status bit i on the same clock edge. Writing 1 to an enable bit that is already 1 leaves its status bit unchanged. No other path clears a status bit.
- R6: If a rising edge of source i reaches the latch on the same clock edge as a write that clears enable bit i, status bit i stays 0.
- R7: A read (`bus_sel_i`=1, `bus_we_i`=0, `bus_addr_i`=0x1E) returns the status in bits 5:0 (bit i = source i) and 0 in bits 7:6. At any other time `bus_rdata_o` is 0.
- R8: In level style (`REQ_STYLE`=REQ_LEVEL), `irq_o` is high exactly while the status is non-zero.
- R9: In pulse style, `irq_o` is high for exactly one cycle, the first cycle in which the status is non-zero after being zero. More bits setting while the status is already non-zero give no further pulse.
- R10: Suppose `src_i[i]` is first sampled high at clock edge k, and the source is enabled. Then status bit i is visible after edge k+2 and not before.
- R11: A write to any address other than 0x1E leaves the enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Asynchronous interrupt source levels |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | DATA_W | Write data (enable mask) |
| bus_rdata_o | output | DATA_W | Read data (latched status) |
| irq_o | output | 1 | Interrupt request, level or pulse |

## Verification
Two functions can act on the same source in one cycle: the edge latch setting a status bit, and an enable write clearing it. The bench provokes this collision on purpose. It drives a source high, waits two clock edges so the synchronised edge arrives exactly on the edge where a disabling write is held on the bus. It then re-enables the source and reads the status, which must show the bit still clear. A behavioural model follows every cycle and compares the read data and both request styles. It does this across directed collisions and a long random stretch, where writes and source edges often coincide.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic {
    REQ_LEVEL = 1'b0,
    REQ_PULSE = 1'b1
  } req_style_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         wr_i,
  input  logic [W-1:0] wmask_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, en_q, st_q;
  logic [W-1:0] rise, en_d;

  assign rise = lvl_i & ~prev_q;
  // a write takes effect this edge; a bit being disabled drops any edge
  assign en_d = wr_i ? wmask_i : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      en_q   <= '0;
      st_q   <= '0;
    end else begin
      prev_q <= lvl_i;
      en_q   <= en_d;
      st_q   <= en_d & (st_q | (rise & en_q));
    end
  end

  assign en_o     = en_q;
  assign status_o = st_q;
endmodule

// File: rtl/eirq_req.sv
module eirq_req #(
  parameter int                      W         = 6,
  parameter eirq_pkg::req_style_e    REQ_STYLE = eirq_pkg::REQ_LEVEL
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  output logic         irq_o
);
  logic any_set;
  assign any_set = |status_i;

  if (REQ_STYLE == eirq_pkg::REQ_PULSE) begin : g_pulse
    logic any_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) any_q <= 1'b0;
      else         any_q <= any_set;
    end
    assign irq_o = any_set & ~any_q;
  end else begin : g_level
    assign irq_o = any_set;
  end
endmodule

// File: rtl/eirq_reg.sv
module eirq_reg #(
  parameter int                   NUM_SRC     = 6,
  parameter int                   DATA_W      = 8,
  parameter int                   ADDR_W      = 5,
  parameter logic [ADDR_W-1:0]    REG_ADDR    = ADDR_W'('h1E),
  parameter int                   SYNC_STAGES = 2,
  parameter eirq_pkg::req_style_e REQ_STYLE   = eirq_pkg::REQ_LEVEL
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic               hit, wr, rd;
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] en_vec, status_vec;

  assign hit = bus_sel_i && (bus_addr_i == REG_ADDR);
  assign wr  = hit &&  bus_we_i;
  assign rd  = hit && !bus_we_i;

  eirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  eirq_latch #(.W(NUM_SRC)) i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (src_sync),
    .wr_i    (wr),
    .wmask_i (bus_wdata_i[NUM_SRC-1:0]),
    .en_o    (en_vec),
    .status_o(status_vec)
  );

  eirq_req #(.W(NUM_SRC), .REQ_STYLE(REQ_STYLE)) i_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_vec),
    .irq_o   (irq_o)
  );

  assign bus_rdata_o = rd ? {{PAD_W{1'b0}}, status_vec} : '0;
endmodule

// File: rtl/eirq_reg_chk.sv
module eirq_reg_chk #(
  parameter int                   NUM_SRC   = 6,
  parameter int                   DATA_W    = 8,
  parameter int                   ADDR_W    = 5,
  parameter logic [ADDR_W-1:0]    REG_ADDR  = ADDR_W'('h1E),
  parameter eirq_pkg::req_style_e REQ_STYLE = eirq_pkg::REQ_LEVEL
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_sel_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] status_vec
);
  logic               wr_c, rd_c;
  logic [NUM_SRC-1:0] keep_mask;

  assign wr_c      = bus_sel_i && bus_we_i && (bus_addr_i == REG_ADDR);
  assign rd_c      = bus_sel_i && !bus_we_i && (bus_addr_i == REG_ADDR);
  assign keep_mask = wr_c ? bus_wdata_i[NUM_SRC-1:0] : '1;

  AST_STATUS_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_vec & ~en_vec) == '0); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_vec & keep_mask) & ~status_vec) == '0)); // R3

  AST_DISABLE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_c |=> ((status_vec & ~$past(bus_wdata_i[NUM_SRC-1:0])) == '0)); // R6

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_c |-> (bus_rdata_o == '0)); // R7

  if (REQ_STYLE == eirq_pkg::REQ_PULSE) begin : g_pulse_chk
    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o); // R9
    AST_PULSE_ON_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ((status_vec != '0) && ($past(status_vec) == '0))); // R9
  end else begin : g_level_chk
    AST_LEVEL_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == (status_vec != '0)); // R8
  end
endmodule

bind eirq_reg eirq_reg_chk #(
  .NUM_SRC  (NUM_SRC),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR),
  .REQ_STYLE(REQ_STYLE)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .en_vec     (en_vec),
  .status_vec (status_vec)
);

// File: tb/test_eirq_reg.sv
module test_eirq_reg;
  localparam int N   = 6;
  localparam int DW  = 8;
  localparam int AW  = 5;
  localparam logic [AW-1:0] RA = 5'h1E;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_lvl, rd_pul;
  logic          irq_lvl, irq_pul;

  always #4 clk = ~clk;

  eirq_reg #(.REQ_STYLE(eirq_pkg::REQ_LEVEL)) i_eirq_reg (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd_lvl), .irq_o(irq_lvl));

  eirq_reg #(.REQ_STYLE(eirq_pkg::REQ_PULSE)) i_eirq_reg_pulse (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd_pul), .irq_o(irq_pul));

  // reference model
  logic [N-1:0] m_en, m_st;
  logic         m_was_set;
  logic [N-1:0] hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_st = '0; m_was_set = 1'b0;
      hist = '{'0, '0, '0};
    end else begin
      logic [N-1:0] new_st, new_en;
      logic wr;
      wr = sel && we && (addr == RA);
      new_en = wr ? wdata[N-1:0] : m_en;
      new_st = m_st;
      for (int i = 0; i < N; i++) begin
        if (hist[1][i] && !hist[2][i] && m_en[i]) new_st[i] = 1'b1;
        if (!new_en[i]) new_st[i] = 1'b0;
      end
      m_was_set = (m_st != '0);
      m_st = new_st;
      m_en = new_en;
      hist.push_front(src);
      void'(hist.pop_back());
    end
  end

  int    n_vec = 0, n_err = 0;
  string tag = "R1";
  bit    done = 1'b0;

  task automatic check(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [DW-1:0] exp_rd;
    exp_rd = (sel && !we && addr == RA) ? DW'(m_st) : '0;
    check("rdata level", rd_lvl, exp_rd);
    check("rdata pulse", rd_pul, exp_rd);
    check("irq level (R8)", DW'(irq_lvl), DW'(m_st != '0));
    check("irq pulse (R9)", DW'(irq_pul), DW'((m_st != '0) && !m_was_set));
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic idle_read();
    sel = 1'b1; we = 1'b0; addr = RA; wdata = '0;
  endtask

  task automatic write_reg(logic [AW-1:0] a, logic [DW-1:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    step();
    idle_read();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state observed with read strobe active
    tag = "R1";
    idle_read();
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    step(3);

    // R4: edges on disabled sources
    tag = "R4";
    src = '1; step(5); src = '0; step(5);

    // R2: enable all, top write bits ignored
    tag = "R2";
    write_reg(RA, 8'hFF);
    step(2);

    // R10: exact latency of one source
    tag = "R10";
    src[0] = 1'b1; step(5);

    // R3: sticky after source falls
    tag = "R3";
    src[0] = 1'b0; step(4);

    // R9: additional bit while already set, no second pulse
    tag = "R9";
    src[3] = 1'b1; step(5);

    // R5: clear by disabling, re-arm
    tag = "R5";
    write_reg(RA, 8'h3E); step(2);
    write_reg(RA, 8'h36); step(2);
    write_reg(RA, 8'h3F); step(3);
    src = '0; step(4);

    // R11: writes elsewhere do not change enables
    tag = "R11";
    write_reg(5'h1D, 8'h00);
    write_reg(5'h00, 8'h00);
    src[1] = 1'b1; step(5);

    // R7: reads at other addresses and writes return zero
    tag = "R7";
    sel = 1'b1; we = 1'b0; addr = 5'h1F; step(2);
    sel = 1'b0; addr = RA; step(2);
    idle_read(); step(1);

    // R8: level follows status through clear
    tag = "R8";
    write_reg(RA, 8'h00); step(2);
    write_reg(RA, 8'h3F); src = '0; step(4);

    // R6: edge arriving on the disabling write edge
    tag = "R6";
    src[2] = 1'b1; step(2);
    write_reg(RA, 8'h3B);
    write_reg(RA, 8'h3F);
    step(4);
    src[2] = 1'b0; step(4);
    src[4] = 1'b1; step(2);
    write_reg(RA, 8'h00);
    write_reg(RA, 8'h3F);
    step(4);
    src = '0; step(3);

    // random stretch
    tag = "R3";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 3) == 0) src[$urandom_range(0, N-1)] ^= 1'b1;
      case ($urandom_range(0, 9))
        0: begin sel = 1'b1; we = 1'b1; addr = RA; wdata = DW'($urandom); end
        1: begin sel = 1'b1; we = 1'b1; addr = AW'($urandom); wdata = DW'($urandom); end
        2: begin sel = 1'b0; we = 1'b0; addr = AW'($urandom); end
        default: idle_read();
      endcase
      step();
    end
    idle_read();
    step(4);
    finish_run();
  end
endmodule